// File: doc/BRIEF.md
# Quadruple Length-Descriptor Packer

This block compresses a stream of 32-bit integers taken four at a time. Each accepted quadruple shares one length, chosen from the largest of its four values. That length is counted in units of a configurable granularity of 1, 2, 4 or 8 bits. The unit count minus one is written as a binary descriptor into a control stream. Each of the four values keeps only its low (count x granularity) bits and is appended to its own 32-bit lane of a four-lane data stream. A value that does not fit in what is left of the current lane word carries over into the next vector.

A producer presents one quadruple per cycle with `in_valid` and marks the final quadruple of a stream with `in_last`. The cycle after that is a flush cycle. In it, any partly filled data vector and any partly filled control unit are emitted with zero padding, and input is not taken. The granularity is a static setting and may change only while reset is held. There is no backpressure: each output word is valid for exactly one cycle.

Top module: `qpk_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, `vec_valid` and `ctl_valid` are 0 and `vec_data` and `ctl_unit` are all zeros. In every cycle where a valid is low, its data output is zero.
- R2: `gran_sel` encodes the unit size as 0 = 1 bit, 1 = 2 bits, 2 = 4 bits and 3 = 8 bits. For each quadruple, let E be the bit length of its maximum value (0 for zero). The descriptor code is ceil(E / unit) - 1, and it is 0 when E is 0. The packed width is (code + 1) x unit bits.
- R3: A descriptor field is 5 - `gran_sel` bits wide. A control unit holds 3, 2, 2 or 4 fields for `gran_sel` 0, 1, 2 or 3. The k-th descriptor of a unit (k from 0) sits at bit k x field width of `ctl_unit`, and unused bits are zero. For `gran_sel` other than 0, only `ctl_unit[7:0]` may be nonzero. A unit is presented in the cycle after the quadruple that fills it.
- R4: Lane i is `in_quad[32i+31:32i]` and maps to `vec_data[32i+31:32i]`. The low packed-width bits of each value are appended LSB-first at the lane's current bit offset, and the offset is the same in all four lanes. A vector is presented in the cycle after the quadruple that completes it.
- R5: When a value overruns bit 31 of the lane word, its low part completes the current vector and its remaining high bits start the next one at bit 0.
- R6: When a value ends exactly at bit 31, the vector is emitted and the next value starts at bit 0 of a fresh vector, with nothing carried over.
- R7: A quadruple accepted with `in_last` = 1 is followed by a flush. One cycle after that quadruple's own results, any partial vector and any partial control unit are presented with zeros in their unused bits. Nothing is presented for a stream that is already empty.
- R8: `in_valid` in the flush cycle has no effect on any output.
- R9: After a flush, data packing restarts at lane bit 0 and descriptor packing at field 0.
- R10: `gran_sel` is held constant outside reset. A new value applied under reset governs all packing after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gran_sel | input | 2 | Unit size select (static) |
| in_valid | input | 1 | Quadruple present this cycle |
| in_last | input | 1 | This quadruple ends the stream |
| in_quad | input | 128 | Four 32-bit values, lane 0 in the low bits |
| ctl_valid | output | 1 | Control unit present |
| ctl_unit | output | 16 | Packed descriptor unit |
| vec_valid | output | 1 | Data vector present |
| vec_data | output | 128 | Four 32-bit packed lane words |

## Verification
Every quadruple's data vector and control unit, when it completes one, is due one clock edge after that quadruple is sampled. A flush result is due one edge later still, which is two edges after the final quadruple. The bench drives each input on a falling edge. Its reference model is built on bit queues and descriptor queues, and it predicts exactly what each output must show after the next rising edge. The bench then compares all four outputs on the following falling edge, every cycle, including cycles where nothing is due.

// File: rtl/qpk_pkg.sv
package qpk_pkg;

    typedef enum logic [1:0] {
        GR_1 = 2'd0,
        GR_2 = 2'd1,
        GR_4 = 2'd2,
        GR_8 = 2'd3
    } gran_e;

    // bits of one binary descriptor field for a unit size
    function automatic logic [2:0] desc_bits(input gran_e g);
        return 3'd5 - {1'b0, g};
    endfunction

    // descriptor fields held by one control unit
    function automatic logic [2:0] unit_slots(input gran_e g);
        case (g)
            GR_1:    return 3'd3;
            GR_8:    return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/qpk_quad_width.sv
module qpk_quad_width #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int CODE_W = $clog2(LANE_W),
    localparam int WID_W  = CODE_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                gran,
    input  logic [LANES*LANE_W-1:0]   quad,
    output logic [CODE_W-1:0]         code,
    output logic [WID_W-1:0]          width
);

    logic [LANE_W-1:0] qmax;
    logic [WID_W-1:0]  ebw;
    logic [WID_W:0]    units;
    logic [WID_W:0]    round_up;
    logic [WID_W-1:0]  cg_w;

    always_comb begin
        qmax = '0;
        for (int l = 0; l < LANES; l++) begin
            if (quad[l*LANE_W +: LANE_W] > qmax) begin
                qmax = quad[l*LANE_W +: LANE_W];
            end
        end
        ebw = '0;
        for (int b = 0; b < LANE_W; b++) begin
            if (qmax[b]) begin
                ebw = WID_W'(b + 1);
            end
        end
        cg_w     = WID_W'(1) << gran;
        round_up = {1'b0, ebw} + {1'b0, cg_w} - 1'b1;
        units    = round_up >> gran;
        if (units == '0) begin
            units = (WID_W+1)'(1);
        end
        code  = CODE_W'(units - 1'b1);
        width = WID_W'(units << gran);
    end

    // packed width holds the quadruple maximum
    assert_width_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (({{LANE_W{1'b0}}, qmax} >> width) == '0));

    // one unit fewer would not hold it
    assert_width_tight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (width > cg_w)) |-> ((qmax >> (width - cg_w)) != '0));

endmodule

// File: rtl/qpk_ctl_stream.sv
module qpk_ctl_stream
    import qpk_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int CTL_W  = 16,
    localparam int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic [1:0]        gran,
    input  logic [CODE_W-1:0] code,
    output logic              ctl_valid,
    output logic [CTL_W-1:0]  ctl_unit
);

    typedef struct packed {
        logic [CTL_W-1:0]  word;
        logic [SLOT_W-1:0] slot;
        logic              vld;
        logic [CTL_W-1:0]  unit;
    } cs_t;

    cs_t s_d, s_q;
    logic [2:0]        fw;
    logic [SLOT_W-1:0] cap;
    logic [CTL_W-1:0]  placed;
    logic [CTL_W-1:0]  merged;

    always_comb begin
        fw     = desc_bits(gran_e'(gran));
        cap    = unit_slots(gran_e'(gran));
        placed = CTL_W'(code) << (int'(s_q.slot) * int'(fw));
        merged = s_q.word | placed;
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.unit = '0;
        if (take) begin
            if (s_q.slot + 1'b1 == cap) begin
                s_d.vld  = 1'b1;
                s_d.unit = merged;
                s_d.word = '0;
                s_d.slot = '0;
            end else begin
                s_d.word = merged;
                s_d.slot = s_q.slot + 1'b1;
            end
        end else if (flush) begin
            if (s_q.slot != '0) begin
                s_d.vld  = 1'b1;
                s_d.unit = s_q.word;
            end
            s_d.word = '0;
            s_d.slot = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_valid = s_q.vld;
    assign ctl_unit  = s_q.unit;

    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.slot < cap);

    assert_narrow_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && gran != 2'd0) |-> (ctl_unit[CTL_W-1:8] == '0));

    assert_code_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((code >> fw) == '0));

    assert_unit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> $past(take || flush));

endmodule

// File: rtl/qpk_data_stream.sv
module qpk_data_stream #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int OFS_W = $clog2(LANE_W),
    localparam int WID_W = OFS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    flush,
    input  logic [WID_W-1:0]        width,
    input  logic [LANES*LANE_W-1:0] quad,
    output logic                    vec_valid,
    output logic [LANES*LANE_W-1:0] vec_data
);

    typedef struct packed {
        logic [LANES-1:0][LANE_W-1:0] acc;
        logic [OFS_W-1:0]             fill;
        logic                         vld;
        logic [LANES-1:0][LANE_W-1:0] vec;
    } ds_t;

    ds_t s_d, s_q;
    logic [WID_W-1:0]                  sum;
    logic [2*LANE_W-1:0]               mask_w;
    logic [LANES-1:0][2*LANE_W-1:0]    joint;

    always_comb begin
        mask_w = ({{(2*LANE_W-1){1'b0}}, 1'b1} << width) - 1'b1;
        sum    = WID_W'(s_q.fill) + width;
        for (int l = 0; l < LANES; l++) begin
            joint[l] = {{LANE_W{1'b0}}, s_q.acc[l]}
                     | (({{LANE_W{1'b0}}, quad[l*LANE_W +: LANE_W]} & mask_w) << s_q.fill);
        end
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.vec = '0;
        if (take) begin
            if (sum >= WID_W'(LANE_W)) begin
                s_d.vld  = 1'b1;
                s_d.fill = OFS_W'(sum - WID_W'(LANE_W));
                for (int l = 0; l < LANES; l++) begin
                    s_d.vec[l] = joint[l][LANE_W-1:0];
                    s_d.acc[l] = joint[l][2*LANE_W-1:LANE_W];
                end
            end else begin
                s_d.fill = sum[OFS_W-1:0];
                for (int l = 0; l < LANES; l++) begin
                    s_d.acc[l] = joint[l][LANE_W-1:0];
                end
            end
        end else if (flush) begin
            if (s_q.fill != '0) begin
                s_d.vld = 1'b1;
                s_d.vec = s_q.acc;
            end
            s_d.acc  = '0;
            s_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_valid = s_q.vld;
    assign vec_data  = s_q.vec;

    assert_vec_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(take || flush));

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (s_q.fill == '0 && s_q.acc == '0));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
            // carried bits never sit above the current offset
            assert_carry_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.acc[g] >> s_q.fill) == '0);
        end
    endgenerate

endmodule

// File: rtl/qpk_packer.sv
module qpk_packer #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int CTL_W  = 16,
    localparam int CODE_W = $clog2(LANE_W),
    localparam int WID_W  = CODE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              gran_sel,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic [LANES*LANE_W-1:0] in_quad,
    output logic                    ctl_valid,
    output logic [CTL_W-1:0]        ctl_unit,
    output logic                    vec_valid,
    output logic [LANES*LANE_W-1:0] vec_data
);

    typedef struct packed {
        logic flush;
    } top_t;

    top_t s_d, s_q;
    logic              take;
    logic [CODE_W-1:0] code;
    logic [WID_W-1:0]  width;

    assign take = in_valid && !s_q.flush;

    always_comb begin
        s_d       = s_q;
        s_d.flush = in_valid && in_last && !s_q.flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    qpk_quad_width #(.LANES(LANES), .LANE_W(LANE_W)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (take),
        .gran     (gran_sel),
        .quad     (in_quad),
        .code     (code),
        .width    (width)
    );

    qpk_ctl_stream #(.CODE_W(CODE_W), .CTL_W(CTL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .flush     (s_q.flush),
        .gran      (gran_sel),
        .code      (code),
        .ctl_valid (ctl_valid),
        .ctl_unit  (ctl_unit)
    );

    qpk_data_stream #(.LANES(LANES), .LANE_W(LANE_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .flush     (s_q.flush),
        .width     (width),
        .quad      (in_quad),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    assert_gran_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(gran_sel));

endmodule

// File: tb/qpk_packer_bench.sv
`timescale 1ns/1ps
module qpk_packer_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   gran_sel = 2'd3;
    logic         in_valid = 1'b0;
    logic         in_last = 1'b0;
    logic [127:0] in_quad = '0;
    logic         ctl_valid;
    logic [15:0]  ctl_unit;
    logic         vec_valid;
    logic [127:0] vec_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] cols[$];
    int         codes[$];
    bit         flush_pend = 0;
    int         g_cur = 3;
    logic [31:0] rng = 32'h1234_5679;

    always #2.5 clk = ~clk;

    qpk_packer u_qpk_packer (
        .clk(clk), .rst_n(rst_n), .gran_sel(gran_sel),
        .in_valid(in_valid), .in_last(in_last), .in_quad(in_quad),
        .ctl_valid(ctl_valid), .ctl_unit(ctl_unit),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    function automatic logic [31:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [127:0] mk(input logic [31:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    function automatic logic [127:0] pop_vec();
        logic [127:0] v = '0;
        for (int b = 0; b < 32; b++) begin
            logic [3:0] c = 4'h0;
            if (cols.size() > 0) c = cols.pop_front();
            for (int l = 0; l < 4; l++) v[l*32+b] = c[l];
        end
        return v;
    endfunction

    function automatic logic [15:0] pop_unit();
        logic [15:0] u = '0;
        int fw = 5 - g_cur;
        for (int i = 0; i < codes.size(); i++) u = u | (16'(codes[i]) << (i*fw));
        codes.delete();
        return u;
    endfunction

    task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic l, input logic [127:0] q, input string tag);
        logic [127:0] ev = '0;
        logic [15:0]  eu = '0;
        bit evv = 0, ecv = 0;
        in_valid = v; in_last = l; in_quad = q;
        if (flush_pend) begin
            flush_pend = 0;
            if (cols.size() > 0) begin evv = 1; ev = pop_vec(); end
            if (codes.size() > 0) begin ecv = 1; eu = pop_unit(); end
        end else if (v) begin
            logic [31:0] mx = '0;
            int ebw = 0, cg = 1 << g_cur, u, w, cap;
            for (int k = 0; k < 4; k++) if (q[k*32 +: 32] > mx) mx = q[k*32 +: 32];
            for (int b = 0; b < 32; b++) if (mx[b]) ebw = b + 1;
            u = (ebw + cg - 1) / cg;
            if (u == 0) u = 1;
            w = u * cg;
            for (int b = 0; b < w; b++) begin
                logic [3:0] c;
                for (int k = 0; k < 4; k++) c[k] = q[k*32 + b];
                cols.push_back(c);
            end
            if (cols.size() >= 32) begin evv = 1; ev = pop_vec(); end
            codes.push_back(u - 1);
            cap = (g_cur == 0) ? 3 : (g_cur == 3) ? 4 : 2;
            if (codes.size() == cap) begin ecv = 1; eu = pop_unit(); end
            flush_pend = l;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "vec_valid", 128'(vec_valid), 128'(evv));
        chk(tag, "vec_data", vec_data, ev);
        chk(tag, "ctl_valid", 128'(ctl_valid), 128'(ecv));
        chk(tag, "ctl_unit", 128'(ctl_unit), 128'(eu));
    endtask

    task automatic do_reset(input int g, input string tag);
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_last = 0; in_quad = '0;
        gran_sel = 2'(g);
        g_cur = g;
        cols.delete(); codes.delete(); flush_pend = 0;
        repeat (3) @(negedge clk);
        chk(tag, "vec_valid in reset", 128'(vec_valid), 128'(0));
        chk(tag, "ctl_valid in reset", 128'(ctl_valid), 128'(0));
        rst_n = 1;
        @(negedge clk);
        chk(tag, "vec_data after reset", vec_data, '0);
        chk(tag, "ctl_unit after reset", 128'(ctl_unit), 128'(0));
    endtask

    task automatic rand_burst(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a[4];
            int sh = int'(next_rand() % 32);
            for (int k = 0; k < 4; k++) a[k] = next_rand() >> sh;
            if (next_rand() % 9 == 0) a = '{0, 0, 0, 0};
            step(1, i == n - 1, mk(a[0], a[1], a[2], a[3]), tag);
        end
        step(0, 0, '0, "R7");
    endtask

    initial begin
        do_reset(3, "R1");
        // exact 8-bit fills, four per vector and four per control unit
        step(1, 0, mk(32'h12, 32'h34, 32'h56, 32'hFF), "R6");
        step(1, 0, mk(32'h0, 32'h0, 32'h0, 32'h0), "R2");
        step(1, 0, mk(32'h80, 32'h1, 32'h2, 32'h3), "R4");
        step(1, 1, mk(32'hAB, 32'hCD, 32'hEF, 32'h10), "R6");
        // flush on an empty stream with valid input present: must be ignored
        step(1, 0, mk(32'hFFFF_FFFF, 32'h7, 32'h7, 32'h7), "R8");
        // 24-bit values split across vector boundary
        step(1, 0, mk(32'hABCDEF, 32'h123456, 32'h1, 32'h0), "R9");
        step(1, 0, mk(32'hFEDCBA, 32'h654321, 32'h800000, 32'h2), "R5");
        step(1, 1, mk(32'h3, 32'h5, 32'h0, 32'h0), "R5");
        step(1, 1, mk(32'hDEAD_BEEF, 32'h1, 32'h1, 32'h1), "R8");
        step(0, 0, '0, "R7");
        rand_burst(40, "R4");

        do_reset(0, "R10");
        step(1, 0, mk(32'h1FF, 32'h3, 32'h0, 32'h100), "R2");
        step(1, 0, mk(32'h0, 32'h0, 32'h0, 32'h0), "R3");
        step(1, 0, mk(32'hFFFF_FFFF, 32'h0, 32'h5, 32'h0), "R3");
        step(1, 1, mk(32'h1, 32'h0, 32'h0, 32'h0), "R7");
        step(0, 0, '0, "R7");
        rand_burst(60, "R3");

        do_reset(1, "R10");
        step(1, 0, mk(32'h1FF, 32'h0, 32'h0, 32'h0), "R2");
        step(1, 1, mk(32'h7, 32'h0, 32'h1, 32'h0), "R7");
        step(0, 0, '0, "R7");
        rand_burst(60, "R2");

        do_reset(2, "R10");
        step(1, 1, mk(32'h1_0000, 32'h0, 32'h0, 32'h0), "R7");
        step(1, 0, mk(32'h5, 32'h5, 32'h5, 32'h5), "R8");
        rand_burst(60, "R5");

        do_reset(3, "R1");
        rand_burst(60, "R6");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule